// File: doc/BRIEF.md
# Bus Access Request and Interrupt Sequencer

This block raises a device's level-1 interrupt request when the device needs the shared system bus, and steps through the grant that the bus controller returns. Two strobes from the read/write control status logic can start a request: one asks for a word transfer and the other reports a transfer error. Either one starts a request only while the access-enable bit of the control register is high. While the request is pending, the block takes over the shared output multiplexer. It drives both select bits high and presents the device number, zero-extended, on the data lines, so the bus controller can identify the requester.

The request stays up until the controller grants the bus. The block then holds bus ownership until the transfer is reported complete. A trigger that arrives while a request or grant is already in progress is kept and served as soon as the current grant finishes. A readable pair of cause bits records whether the transfer strobe, the error strobe or both started the request. A general reset comes from either a master reset pulse or a status-register write. It clears every flip-flop of the block in the clock edge where it is sampled.

Top module: `acc_req_ctrl`

## Requirements
- R1: After the asynchronous reset is released, irq_req, bus_owned, cause_xfer and cause_err are 0, and mux_sel and data_out follow reg_sel and reg_rdata.
- R2: With the block idle and acc_en high, xfer_req or xfer_err high at a clock edge makes irq_req high after that edge.
- R3: A trigger sampled while acc_en is low starts no request and is not held for later. irq_req stays low and the cause bits keep their values.
- R4: irq_req stays high until bus_grant is sampled high. After that edge irq_req is low and bus_owned is high.
- R5: bus_owned stays high until xfer_done is sampled high. After that edge the block is idle, unless a held or new trigger restarts it (see R8).
- R6: When a request starts, cause_xfer takes xfer_req and cause_err takes xfer_err (both set when both strobes are high). The bits keep these values until the next request starts or a general reset occurs.
- R7: While irq_req is high, mux_sel is 2'b11 and data_out is DEV_NUM zero-extended to DATA_W. Otherwise mux_sel equals reg_sel and data_out equals reg_rdata.
- R8: An enabled trigger sampled while a request or grant is in progress is held. At the edge where xfer_done ends the grant, irq_req rises again. Its cause bits are the OR of the held triggers and of any trigger in that same edge.
- R9: mst_rst or stat_wr high at an edge clears the request, the ownership, the held trigger and the cause bits. This takes priority over any trigger in the same edge.
- R10: bus_grant is ignored unless a request is pending, and xfer_done is ignored unless the bus is owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_rst | input | 1 | Master reset pulse (general reset) |
| stat_wr | input | 1 | Status-register write strobe (general reset) |
| acc_en | input | 1 | Control-register access-enable bit |
| xfer_req | input | 1 | Word-transfer request strobe |
| xfer_err | input | 1 | Transfer-error strobe |
| bus_grant | input | 1 | Bus controller grants access |
| xfer_done | input | 1 | Granted transfer has completed |
| reg_sel | input | 2 | Normal register-decode select bits |
| reg_rdata | input | DATA_W | Normal register read data |
| irq_req | output | 1 | Level-1 interrupt bus request |
| bus_owned | output | 1 | Bus granted to the device |
| cause_xfer | output | 1 | Latched cause: transfer request |
| cause_err | output | 1 | Latched cause: transfer error |
| mux_sel | output | 2 | Output multiplexer select |
| data_out | output | DATA_W | Data presented to the bus lines |

## Verification
The assertions assume that the bus controller asserts bus_grant and xfer_done as single-cycle strobes that are synchronous to clk. They also assume that the general-reset strobes are sampled at clock edges like any other input. The bench drives every input at the falling edge and holds it through the following rising edge, so no strobe changes near a sampling point. The bench raises a grant or a completion both in the phase where it takes effect and in phases where it must be ignored. Triggers are placed in the idle, requesting and owning phases, and in the same edge as a completion or a general reset, so that each priority rule is exercised.

// File: rtl/acc_req_pkg.sv
package acc_req_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_REQ  = 2'd1,
      SEQ_OWN  = 2'd2
   } seq_state_e;

   // bit 0: transfer request, bit 1: transfer error
   typedef struct packed {
      logic err;
      logic xfer;
   } cause_t;

   localparam cause_t CAUSE_NONE = '{err: 1'b0, xfer: 1'b0};

endpackage

// File: rtl/acc_trig_capture.sv
module acc_trig_capture
   import acc_req_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   gen_rst,
   input  logic   acc_en,
   input  logic   xfer_req,
   input  logic   xfer_err,
   input  logic   busy,
   input  logic   launch,
   output logic   hit,
   output cause_t hit_cause,
   output logic   held,
   output cause_t held_cause
);

   always_comb begin
      hit_cause.xfer = xfer_req;
      hit_cause.err  = xfer_err;
      hit            = acc_en && (xfer_req || xfer_err);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held       <= 1'b0;
         held_cause <= CAUSE_NONE;
      end else if (gen_rst) begin
         held       <= 1'b0;
         held_cause <= CAUSE_NONE;
      end else if (launch) begin
         // the sequencer consumes held and same-edge triggers together
         held       <= 1'b0;
         held_cause <= CAUSE_NONE;
      end else if (hit && busy) begin
         held       <= 1'b1;
         held_cause <= held_cause | hit_cause;
      end
   end

   assert_held_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !gen_rst && !launch) |=> held);

   assert_held_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gen_rst |=> (!held && held_cause == CAUSE_NONE));

endmodule

// File: rtl/acc_seq.sv
module acc_seq
   import acc_req_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   gen_rst,
   input  logic   hit,
   input  cause_t hit_cause,
   input  logic   held,
   input  cause_t held_cause,
   input  logic   bus_grant,
   input  logic   xfer_done,
   output logic   busy,
   output logic   launch,
   output logic   req_act,
   output logic   own_act,
   output cause_t cur_cause
);

   seq_state_e state_q, state_d;
   cause_t     cause_d;
   cause_t     relaunch_cause;

   always_comb begin
      relaunch_cause = held_cause | (hit ? hit_cause : CAUSE_NONE);
      launch         = (state_q == SEQ_OWN) && xfer_done;
      state_d        = state_q;
      cause_d        = cur_cause;
      unique case (state_q)
         SEQ_IDLE: if (hit) begin
            state_d = SEQ_REQ;
            cause_d = hit_cause;
         end
         SEQ_REQ: if (bus_grant) state_d = SEQ_OWN;
         SEQ_OWN: if (xfer_done) begin
            if (held || hit) begin
               state_d = SEQ_REQ;
               cause_d = relaunch_cause;
            end else begin
               state_d = SEQ_IDLE;
            end
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         cur_cause <= CAUSE_NONE;
      end else if (gen_rst) begin
         state_q   <= SEQ_IDLE;
         cur_cause <= CAUSE_NONE;
      end else begin
         state_q   <= state_d;
         cur_cause <= cause_d;
      end
   end

   assign busy    = (state_q != SEQ_IDLE);
   assign req_act = (state_q == SEQ_REQ);
   assign own_act = (state_q == SEQ_OWN);

   assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_act && !bus_grant && !gen_rst) |=> req_act);

   assert_grant_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_act && bus_grant && !gen_rst) |=> (own_act && !req_act));

   assert_own_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_act && !xfer_done && !gen_rst) |=> own_act);

   assert_idle_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !hit && !gen_rst) |=> !busy);

   assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_act, own_act}));

endmodule

// File: rtl/acc_out_mux.sv
module acc_out_mux #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DEV_W   = 8,
   parameter int unsigned SEL_W   = 2,
   parameter logic [DEV_W-1:0] DEV_NUM = '0
) (
   input  logic              req_act,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [SEL_W-1:0]  mux_sel,
   output logic [DATA_W-1:0] data_out
);

   localparam int unsigned PAD_W = DATA_W - DEV_W;

   logic [DATA_W-1:0] dev_word;

   generate
      if (PAD_W == 0) begin : g_nopad
         assign dev_word = DEV_NUM;
      end else begin : g_pad
         assign dev_word = {{PAD_W{1'b0}}, DEV_NUM};
      end
   endgenerate

   always_comb begin
      mux_sel  = req_act ? {SEL_W{1'b1}} : reg_sel;
      data_out = req_act ? dev_word : reg_rdata;
   end

endmodule

// File: rtl/acc_req_ctrl.sv
module acc_req_ctrl
   import acc_req_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DEV_W   = 8,
   parameter int unsigned SEL_W   = 2,
   parameter logic [DEV_W-1:0] DEV_NUM = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mst_rst,
   input  logic              stat_wr,
   input  logic              acc_en,
   input  logic              xfer_req,
   input  logic              xfer_err,
   input  logic              bus_grant,
   input  logic              xfer_done,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              irq_req,
   output logic              bus_owned,
   output logic              cause_xfer,
   output logic              cause_err,
   output logic [SEL_W-1:0]  mux_sel,
   output logic [DATA_W-1:0] data_out
);

   localparam logic [DATA_W-1:0] DEV_WORD = DATA_W'(DEV_NUM);

   initial begin
      if (DEV_W > DATA_W) $error("DEV_W must not exceed DATA_W");
      if (DEV_W == 0)     $error("DEV_W must be non-zero");
      if (SEL_W != 2)     $error("SEL_W must be 2");
   end

   logic   gen_rst;
   logic   hit, held, busy, launch, req_act, own_act;
   cause_t hit_cause, held_cause, cur_cause;

   assign gen_rst = mst_rst || stat_wr;

   acc_trig_capture u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .gen_rst    (gen_rst),
      .acc_en     (acc_en),
      .xfer_req   (xfer_req),
      .xfer_err   (xfer_err),
      .busy       (busy),
      .launch     (launch),
      .hit        (hit),
      .hit_cause  (hit_cause),
      .held       (held),
      .held_cause (held_cause)
   );

   acc_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .gen_rst    (gen_rst),
      .hit        (hit),
      .hit_cause  (hit_cause),
      .held       (held),
      .held_cause (held_cause),
      .bus_grant  (bus_grant),
      .xfer_done  (xfer_done),
      .busy       (busy),
      .launch     (launch),
      .req_act    (req_act),
      .own_act    (own_act),
      .cur_cause  (cur_cause)
   );

   acc_out_mux #(
      .DATA_W  (DATA_W),
      .DEV_W   (DEV_W),
      .SEL_W   (SEL_W),
      .DEV_NUM (DEV_NUM)
   ) u_mux (
      .req_act   (req_act),
      .reg_sel   (reg_sel),
      .reg_rdata (reg_rdata),
      .mux_sel   (mux_sel),
      .data_out  (data_out)
   );

   assign irq_req    = req_act;
   assign bus_owned  = own_act;
   assign cause_xfer = cur_cause.xfer;
   assign cause_err  = cur_cause.err;

   assert_dev_on_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (mux_sel == {SEL_W{1'b1}} && data_out == DEV_WORD));

   assert_general_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gen_rst |=> (!irq_req && !bus_owned && !cause_xfer && !cause_err));

   assert_rise_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ($past(acc_en && (xfer_req || xfer_err)) || $past(held)));

   assert_cause_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (cause_xfer || cause_err));

endmodule

// File: tb/acc_req_ctrl_tb_top.sv
module acc_req_ctrl_tb_top;

   localparam int unsigned DATA_W = 16;
   localparam logic [7:0]  DEV    = 8'hC3;

   typedef struct {
      logic              irq;
      logic              own;
      logic [1:0]        cause;   // {err, xfer}
      logic [1:0]        sel;
      logic [DATA_W-1:0] data;
      string             tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mst_rst = 0, stat_wr = 0, acc_en = 0, xfer_req = 0, xfer_err = 0;
   logic bus_grant = 0, xfer_done = 0;
   logic [1:0]        reg_sel = 2'b01;
   logic [DATA_W-1:0] reg_rdata = 16'h1234;
   logic irq_req, bus_owned, cause_xfer, cause_err;
   logic [1:0]        mux_sel;
   logic [DATA_W-1:0] data_out;

   int   n_vec = 0;
   int   n_bad = 0;
   exp_t sb_q[$];

   always #2 clk = ~clk;   // 250 MHz

   acc_req_ctrl #(.DATA_W(DATA_W), .DEV_W(8), .SEL_W(2), .DEV_NUM(DEV)) dut_i (
      .clk(clk), .rst_n(rst_n), .mst_rst(mst_rst), .stat_wr(stat_wr),
      .acc_en(acc_en), .xfer_req(xfer_req), .xfer_err(xfer_err),
      .bus_grant(bus_grant), .xfer_done(xfer_done), .reg_sel(reg_sel),
      .reg_rdata(reg_rdata), .irq_req(irq_req), .bus_owned(bus_owned),
      .cause_xfer(cause_xfer), .cause_err(cause_err), .mux_sel(mux_sel),
      .data_out(data_out)
   );

   // driver: set inputs at the falling edge, queue the result expected after the next rising edge
   task automatic cyc(input logic tx, te, en, gr, dn, sw, mr,
                      input logic eirq, eown, input logic [1:0] ecause, input string tag);
      exp_t e;
      @(negedge clk);
      xfer_req = tx; xfer_err = te; acc_en = en; bus_grant = gr;
      xfer_done = dn; stat_wr = sw; mst_rst = mr;
      e.irq = eirq; e.own = eown; e.cause = ecause;
      e.sel  = eirq ? 2'b11 : reg_sel;
      e.data = eirq ? {8'h00, DEV} : reg_rdata;
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   task automatic compare(input exp_t e);
      n_vec++;
      if (irq_req !== e.irq || bus_owned !== e.own || {cause_err, cause_xfer} !== e.cause ||
          mux_sel !== e.sel || data_out !== e.data) begin
         n_bad++;
         $display("FAIL %s: got irq=%b own=%b cause=%b sel=%b data=%h, expected irq=%b own=%b cause=%b sel=%b data=%h",
                  e.tag, irq_req, bus_owned, {cause_err, cause_xfer}, mux_sel, data_out,
                  e.irq, e.own, e.cause, e.sel, e.data);
      end
   endtask

   // monitor: after each rising edge, compare against the oldest expectation
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) compare(sb_q.pop_front());
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk); rst_n = 1'b1;
            #1;
            // R1: reset state checked directly
            n_vec++;
            if (irq_req !== 0 || bus_owned !== 0 || cause_xfer !== 0 || cause_err !== 0 ||
                mux_sel !== reg_sel || data_out !== reg_rdata) begin
               n_bad++;
               $display("FAIL R1: got irq=%b own=%b cause=%b sel=%b data=%h, expected 0 0 00 %b %h",
                        irq_req, bus_owned, {cause_err, cause_xfer}, mux_sel, data_out, reg_sel, reg_rdata);
            end
            cyc(0,0,0,0,0,0,0, 0,0,2'b00, "R1");
            // transfer request
            cyc(1,0,1,0,0,0,0, 1,0,2'b01, "R2");
            cyc(0,0,1,0,0,0,0, 1,0,2'b01, "R4");
            cyc(0,0,1,0,0,0,0, 1,0,2'b01, "R7");
            cyc(0,0,1,1,0,0,0, 0,1,2'b01, "R4");
            cyc(0,0,1,0,0,0,0, 0,1,2'b01, "R5");
            cyc(0,0,1,0,1,0,0, 0,0,2'b01, "R5");
            // disabled triggers
            cyc(0,1,0,0,0,0,0, 0,0,2'b01, "R3");
            cyc(1,0,0,0,0,0,0, 0,0,2'b01, "R3");
            cyc(0,0,1,0,0,0,0, 0,0,2'b01, "R3");
            // grant/done ignored while idle
            cyc(0,0,1,1,1,0,0, 0,0,2'b01, "R10");
            // error request, done ignored in REQ, held trigger
            @(negedge clk); reg_sel = 2'b10; reg_rdata = 16'hBEEF;
            cyc(0,1,1,0,0,0,0, 1,0,2'b10, "R6");
            cyc(0,0,1,0,1,0,0, 1,0,2'b10, "R10");
            cyc(1,0,1,0,0,0,0, 1,0,2'b10, "R8");
            cyc(0,1,0,0,0,0,0, 1,0,2'b10, "R3");   // disabled, not held
            cyc(0,0,1,1,0,0,0, 0,1,2'b10, "R4");
            cyc(0,0,1,1,0,0,0, 0,1,2'b10, "R10");
            cyc(0,0,1,0,1,0,0, 1,0,2'b01, "R8");
            cyc(0,0,1,1,0,0,0, 0,1,2'b01, "R4");
            cyc(0,0,1,0,1,0,0, 0,0,2'b01, "R5");
            cyc(0,0,1,0,0,0,0, 0,0,2'b01, "R7");
            // both strobes, then trigger in same edge as done
            cyc(1,1,1,0,0,0,0, 1,0,2'b11, "R6");
            cyc(0,0,1,1,0,0,0, 0,1,2'b11, "R4");
            cyc(0,1,1,0,1,0,0, 1,0,2'b10, "R8");
            // status write clears, overrides trigger
            cyc(1,0,1,0,0,1,0, 0,0,2'b00, "R9");
            cyc(0,0,1,0,0,0,0, 0,0,2'b00, "R9");
            // held trigger wiped by master reset
            cyc(1,0,1,0,0,0,0, 1,0,2'b01, "R2");
            cyc(0,1,1,0,0,0,0, 1,0,2'b01, "R8");
            cyc(0,0,1,1,0,0,0, 0,1,2'b01, "R4");
            cyc(0,0,1,0,0,0,1, 0,0,2'b00, "R9");
            cyc(1,0,1,0,0,0,0, 1,0,2'b01, "R2");
            cyc(0,0,1,1,0,0,0, 0,1,2'b01, "R4");
            cyc(0,0,1,0,1,0,0, 0,0,2'b01, "R9");
            cyc(0,0,1,0,0,0,0, 0,0,2'b01, "R9");
            cyc(0,0,0,0,0,0,0, 0,0,2'b01, "R1");
            repeat (3) @(posedge clk);
            #2;
         end
         begin
            repeat (5000) @(posedge clk);
            n_vec++; n_bad++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule